// File: doc/BRIEF.md
# Dual Down-Counting Timer with APB Register Access

The block holds two independent down-counting timers behind one APB slave port. Software programs a start count, picks a count mode and width, and chooses a clock divider. Each timer then decrements once per divided clock tick and raises an interrupt when its count reaches zero. Three count modes are available. Free-running wraps to all ones after zero. Periodic reloads a stored value after zero. One-shot stops at zero.

Each timer has a bank of seven word registers. The second timer's bank sits 0x20 above the first. The bank has a start value (LOAD), the live count (VALUE), the mode settings (CONTROL), a write-only interrupt clear (INTCLR), the raw and masked interrupt flags (RIS, MIS), and a reload-only start value (BGLOAD). Each timer drives its own interrupt line. A combined line is also provided for integrators that need only one.

Top module: `dual_timer_apb`

## Requirements
- R1: After reset, VALUE reads 0xFFFFFFFF, CONTROL reads 0x20, LOAD, RIS and MIS read 0, and all interrupt outputs are low, for both timers.
- R2: While CONTROL bit 7 is set, the count drops by one per prescaled tick. CONTROL[3:2] picks the divider: 00 gives /1, 01 gives /16, and 10 or 11 give /256. The divider restarts on enable, so the first decrement lands exactly one divider period after the enabling write.
- R3: In free-running mode (bit 6 = 0, bit 0 = 0), the tick that finds the count at zero wraps it to all ones in the active width.
- R4: In periodic mode (bit 6 = 1, bit 0 = 0), the tick that finds the count at zero reloads it with the stored reload value.
- R5: In one-shot mode (bit 0 = 1, which takes priority over bit 6), the count holds at zero. A later LOAD write restarts the count from the written value, even while the timer is enabled.
- R6: RIS bit 0 sets on the tick that takes the count from 1 to 0. A write of any data value to INTCLR clears it.
- R7: MIS bit 0 equals RIS AND CONTROL bit 5. tmr_irq_o[n] equals the MIS of timer n, and irq_any_o is the OR of the two.
- R8: A BGLOAD write changes only the reload value, and the running count is untouched. A LOAD write sets both the reload value and the count at once. LOAD and BGLOAD both read back the reload value.
- R9: With CONTROL bit 1 = 0 (16-bit mode), decrement, zero detection, wrap and reload act only on bits 15:0 of the count. Bits 31:16 of VALUE keep their value.
- R10: When an INTCLR write and the expiring tick fall in the same cycle, RIS ends set.
- R11: The register offsets are LOAD 0x00, VALUE 0x04, CONTROL 0x08, INTCLR 0x0C, RIS 0x10, MIS 0x14 and BGLOAD 0x18, with timer 2 at +0x20. CONTROL reads back bits 7:5 and 3:0 as written, and bit 4 and bits 31:8 read 0. INTCLR, offset 0x1C or 0x3C, and any address at or above 0x40 read 0. Every access takes one setup cycle and one access cycle, with no wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when high |
| paddr_i | input | ADDR_W (8) | APB byte address |
| pwdata_i | input | DATA_W (32) | APB write data |
| prdata_o | output | DATA_W (32) | APB read data |
| tmr_irq_o | output | NUM_TMR (2) | Per-timer masked interrupt |
| irq_any_o | output | 1 | OR of all timer interrupts |

## Verification
The interrupt clear and the expiring tick can land in the same clock edge. So can a LOAD write and a prescaled tick. The bench counts clock edges from the enabling write and places an INTCLR write exactly on the edge where the count reaches zero. It then expects RIS still set, and a second clear one transfer later must take it to 0. A LOAD write is aligned to a known phase of the /16 divider, and the count must show the new value rather than a decremented old one.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;

  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NARROW_W = 16;
  localparam int unsigned CTRL_W   = 8;

  typedef enum logic [2:0] {
    REG_LOAD  = 3'd0,
    REG_VALUE = 3'd1,
    REG_CTRL  = 3'd2,
    REG_CLR   = 3'd3,
    REG_RAW   = 3'd4,
    REG_MASK  = 3'd5,
    REG_BG    = 3'd6,
    REG_NONE  = 3'd7
  } reg_sel_e;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       irq_en;
    logic [1:0] div;
    logic       wide;
    logic       one_shot;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{en: 1'b0, periodic: 1'b0, irq_en: 1'b1,
                                 div: 2'b00, wide: 1'b0, one_shot: 1'b0};

  function automatic logic [CTRL_W-1:0] ctrl_pack(ctrl_t c);
    return {c.en, c.periodic, c.irq_en, 1'b0, c.div, c.wide, c.one_shot};
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.en       = w[7];
    c.periodic = w[6];
    c.irq_en   = w[5];
    c.div      = w[3:2];
    c.wide     = w[1];
    c.one_shot = w[0];
    return c;
  endfunction

endpackage

// File: rtl/dual_timer_prescale.sv
module dual_timer_prescale #(
  parameter int unsigned DIV1_LOG = 4,
  parameter int unsigned DIV2_LOG = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] div_i,
  output logic       tick_o
);

  logic [DIV2_LOG-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pre_q <= '0;
    else if (en_i) pre_q <= pre_q + 1'b1;
    else           pre_q <= '0;
  end

  always_comb begin
    unique case (div_i)
      2'b00:   tick_o = en_i;
      2'b01:   tick_o = en_i & (&pre_q[DIV1_LOG-1:0]);
      default: tick_o = en_i & (&pre_q);
    endcase
  end

endmodule

// File: rtl/dual_timer_core.sv
module dual_timer_core
  import dual_timer_pkg::*;
#(
  parameter int unsigned DATA_W   = dual_timer_pkg::DATA_W,
  parameter int unsigned NARROW_W = dual_timer_pkg::NARROW_W,
  parameter int unsigned DIV1_LOG = 4,
  parameter int unsigned DIV2_LOG = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_wr_i,
  input  logic              bg_wr_i,
  input  logic              ctrl_wr_i,
  input  logic              clr_wr_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic [DATA_W-1:0] reload_o,
  output ctrl_t             ctrl_o,
  output logic              ris_o,
  output logic              tick_o,
  output logic              expire_o
);

  localparam logic [DATA_W-1:0] NARROW_MASK =
    {{(DATA_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [DATA_W-1:0] cnt_q, cnt_d, reload_q, act_mask;
  logic [DATA_W-1:0] cnt_act, cnt_dec, cnt_wrap, cnt_rel;
  ctrl_t             ctrl_q;
  logic              ris_q, tick, zero, one;

  dual_timer_prescale #(
    .DIV1_LOG(DIV1_LOG),
    .DIV2_LOG(DIV2_LOG)
  ) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (ctrl_q.en),
    .div_i (ctrl_q.div),
    .tick_o(tick)
  );

  assign act_mask = ctrl_q.wide ? '1 : NARROW_MASK;
  assign cnt_act  = cnt_q & act_mask;
  assign zero     = (cnt_act == '0);
  assign one      = (cnt_act == {{(DATA_W-1){1'b0}}, 1'b1});
  // untouched upper half merged back in 16-bit mode
  assign cnt_dec  = (cnt_q & ~act_mask) | ((cnt_q - 1'b1) & act_mask);
  assign cnt_wrap = cnt_q | act_mask;
  assign cnt_rel  = (cnt_q & ~act_mask) | (reload_q & act_mask);

  always_comb begin
    cnt_d = cnt_q;
    if (load_wr_i) begin
      cnt_d = wdata_i;
    end else if (tick) begin
      if (!zero)                cnt_d = cnt_dec;
      else if (ctrl_q.one_shot) cnt_d = cnt_q;
      else if (ctrl_q.periodic) cnt_d = cnt_rel;
      else                      cnt_d = cnt_wrap;
    end
  end

  assign expire_o = tick & one & ~load_wr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '1;
      reload_q <= '0;
      ctrl_q   <= CTRL_RST;
      ris_q    <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      if (load_wr_i || bg_wr_i) reload_q <= wdata_i;
      if (ctrl_wr_i)            ctrl_q   <= ctrl_unpack(wdata_i[CTRL_W-1:0]);
      if (expire_o)             ris_q    <= 1'b1;
      else if (clr_wr_i)        ris_q    <= 1'b0;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign ctrl_o   = ctrl_q;
  assign ris_o    = ris_q;
  assign tick_o   = tick;

endmodule

// File: rtl/dual_timer_regs.sv
module dual_timer_regs
  import dual_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = dual_timer_pkg::DATA_W,
  parameter int unsigned NUM_TMR = 2
) (
  input  logic                            psel_i,
  input  logic                            penable_i,
  input  logic                            pwrite_i,
  input  logic [ADDR_W-1:0]               paddr_i,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  cnt_i,
  input  logic [NUM_TMR-1:0][DATA_W-1:0]  reload_i,
  input  logic [NUM_TMR-1:0][CTRL_W-1:0]  ctrl_i,
  input  logic [NUM_TMR-1:0]              ris_i,
  input  logic [NUM_TMR-1:0]              mis_i,
  output logic [NUM_TMR-1:0]              load_wr_o,
  output logic [NUM_TMR-1:0]              bg_wr_o,
  output logic [NUM_TMR-1:0]              ctrl_wr_o,
  output logic [NUM_TMR-1:0]              clr_wr_o,
  output logic [DATA_W-1:0]               prdata_o
);

  localparam int unsigned BANK_LSB = 5;
  localparam int unsigned BANK_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1;
  localparam int unsigned HI_LSB   = BANK_LSB + BANK_W;

  logic [BANK_W-1:0] bank;
  reg_sel_e          sel;
  logic              hit, wr;
  logic              unused_addr;

  assign unused_addr = ^paddr_i[1:0];
  assign bank = paddr_i[BANK_LSB +: BANK_W];
  assign sel  = reg_sel_e'(paddr_i[4:2]);
  assign hit  = (paddr_i[ADDR_W-1:HI_LSB] == '0) && (int'(bank) < NUM_TMR);
  assign wr   = psel_i & penable_i & pwrite_i & hit;

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_strobe
    logic mine;
    assign mine         = wr && (int'(bank) == t);
    assign load_wr_o[t] = mine && (sel == REG_LOAD);
    assign bg_wr_o[t]   = mine && (sel == REG_BG);
    assign ctrl_wr_o[t] = mine && (sel == REG_CTRL);
    assign clr_wr_o[t]  = mine && (sel == REG_CLR);
  end

  always_comb begin
    prdata_o = '0;
    if (hit) begin
      for (int t = 0; t < NUM_TMR; t++) begin
        if (int'(bank) == t) begin
          unique case (sel)
            REG_LOAD, REG_BG: prdata_o = reload_i[t];
            REG_VALUE:        prdata_o = cnt_i[t];
            REG_CTRL:         prdata_o = {{(DATA_W-CTRL_W){1'b0}}, ctrl_i[t]};
            REG_RAW:          prdata_o = {{(DATA_W-1){1'b0}}, ris_i[t]};
            REG_MASK:         prdata_o = {{(DATA_W-1){1'b0}}, mis_i[t]};
            default:          prdata_o = '0;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/dual_timer_apb.sv
module dual_timer_apb
  import dual_timer_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DATA_W   = dual_timer_pkg::DATA_W,
  parameter int unsigned NARROW_W = dual_timer_pkg::NARROW_W,
  parameter int unsigned NUM_TMR  = 2,
  parameter int unsigned DIV1_LOG = 4,
  parameter int unsigned DIV2_LOG = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [DATA_W-1:0]  pwdata_i,
  output logic [DATA_W-1:0]  prdata_o,
  output logic [NUM_TMR-1:0] tmr_irq_o,
  output logic               irq_any_o
);

  logic [NUM_TMR-1:0][DATA_W-1:0] cnt_w, reload_w;
  logic [NUM_TMR-1:0][CTRL_W-1:0] ctrl_word_w;
  logic [NUM_TMR-1:0] load_wr_w, bg_wr_w, ctrl_wr_w, clr_wr_w;
  logic [NUM_TMR-1:0] ris_w, mis_w, tick_w, exp_w;
  logic [NUM_TMR-1:0] en_w, wide_w, os_w;

  dual_timer_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_TMR(NUM_TMR)
  ) u_regs (
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .cnt_i    (cnt_w),
    .reload_i (reload_w),
    .ctrl_i   (ctrl_word_w),
    .ris_i    (ris_w),
    .mis_i    (mis_w),
    .load_wr_o(load_wr_w),
    .bg_wr_o  (bg_wr_w),
    .ctrl_wr_o(ctrl_wr_w),
    .clr_wr_o (clr_wr_w),
    .prdata_o (prdata_o)
  );

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    ctrl_t ctrl;

    dual_timer_core #(
      .DATA_W  (DATA_W),
      .NARROW_W(NARROW_W),
      .DIV1_LOG(DIV1_LOG),
      .DIV2_LOG(DIV2_LOG)
    ) u_core (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wdata_i  (pwdata_i),
      .load_wr_i(load_wr_w[t]),
      .bg_wr_i  (bg_wr_w[t]),
      .ctrl_wr_i(ctrl_wr_w[t]),
      .clr_wr_i (clr_wr_w[t]),
      .cnt_o    (cnt_w[t]),
      .reload_o (reload_w[t]),
      .ctrl_o   (ctrl),
      .ris_o    (ris_w[t]),
      .tick_o   (tick_w[t]),
      .expire_o (exp_w[t])
    );

    assign ctrl_word_w[t] = ctrl_pack(ctrl);
    assign mis_w[t]       = ris_w[t] & ctrl.irq_en;
    assign en_w[t]        = ctrl.en;
    assign wide_w[t]      = ctrl.wide;
    assign os_w[t]        = ctrl.one_shot;
  end

  assign tmr_irq_o = mis_w;
  assign irq_any_o = |mis_w;

endmodule

// File: rtl/dual_timer_apb_chk.sv
module dual_timer_apb_chk #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NARROW_W = 16,
  parameter int unsigned NUM_TMR  = 2
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic [NUM_TMR-1:0][DATA_W-1:0] cnt_i,
  input logic [NUM_TMR-1:0]             tick_i,
  input logic [NUM_TMR-1:0]             exp_i,
  input logic [NUM_TMR-1:0]             load_wr_i,
  input logic [NUM_TMR-1:0]             bg_wr_i,
  input logic [NUM_TMR-1:0]             ctrl_wr_i,
  input logic [NUM_TMR-1:0]             clr_wr_i,
  input logic [NUM_TMR-1:0]             ris_i,
  input logic [NUM_TMR-1:0]             en_i,
  input logic [NUM_TMR-1:0]             wide_i,
  input logic [NUM_TMR-1:0]             os_i,
  input logic [NUM_TMR-1:0]             irq_i
);

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chk
    logic at_zero;
    assign at_zero = wide_i[t] ? (cnt_i[t] == '0) : (cnt_i[t][NARROW_W-1:0] == '0);

    a_r6_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_wr_i[t] && !exp_i[t] |=> !ris_i[t]);

    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exp_i[t] |=> ris_i[t]);

    a_r5_oneshot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i[t] && os_i[t] && at_zero && !load_wr_i[t] && !ctrl_wr_i[t]
      |=> cnt_i[t] == $past(cnt_i[t]));

    a_r8_bg_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bg_wr_i[t] && !tick_i[t] |=> $stable(cnt_i[t]));

    a_r2_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i[t] && wide_i[t] && !at_zero && !load_wr_i[t]
      |=> cnt_i[t] == $past(cnt_i[t]) - 1'b1);

    a_r7_irq_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_i[t] |-> ris_i[t]);
  end

endmodule

bind dual_timer_apb dual_timer_apb_chk #(
  .DATA_W  (DATA_W),
  .NARROW_W(NARROW_W),
  .NUM_TMR (NUM_TMR)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cnt_i    (cnt_w),
  .tick_i   (tick_w),
  .exp_i    (exp_w),
  .load_wr_i(load_wr_w),
  .bg_wr_i  (bg_wr_w),
  .ctrl_wr_i(ctrl_wr_w),
  .clr_wr_i (clr_wr_w),
  .ris_i    (ris_w),
  .en_i     (en_w),
  .wide_i   (wide_w),
  .os_i     (os_w),
  .irq_i    (tmr_irq_o)
);

// File: tb/tb_dual_timer_apb.sv
module tb_dual_timer_apb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic [1:0]  irq;
  logic        irq_any;

  always #5 clk = ~clk;

  dual_timer_apb dut (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
    .prdata_o(prdata), .tmr_irq_o(irq), .irq_any_o(irq_any)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  int cyc_en, last_wr, s_cyc;
  logic [1:0] s_irq;
  logic s_any;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr_now(logic [7:0] a, logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk) penable = 1'b1;
    @(posedge clk); #1;
    last_wr = cyc; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_now(a, d);
  endtask

  // write edge lands so that cyc == t right after it
  task automatic wr_at(logic [7:0] a, logic [31:0] d, int t);
    do @(negedge clk); while (cyc != t - 2);
    wr_now(a, d);
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk) penable = 1'b1;
    #1 d = prdata; s_cyc = cyc; s_irq = irq; s_any = irq_any;
    @(posedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  function automatic logic [31:0] mdl_val(logic [31:0] load, longint ticks, int mode, bit w);
    longint m, l, v;
    logic [31:0] up;
    m  = w ? 64'hFFFF_FFFF : 64'hFFFF;
    up = w ? 32'h0 : (load & 32'hFFFF_0000);
    l  = longint'(load) & m;
    if (mode == 0)      v = (ticks <= l) ? l - ticks : m - ((ticks - l - 1) % (m + 1));
    else if (mode == 1) v = l - (ticks % (l + 1));
    else                v = (ticks >= l) ? 0 : l - ticks;
    return up | 32'(v);
  endfunction

  task automatic run_cfg(int tm, int sel, int mode, bit w, bit ie, logic [31:0] load, string tag);
    logic [7:0]  base;
    logic [31:0] v, ctrl;
    int div, n, lo;
    string rq;
    bit exp_ris;
    base = 8'(tm * 32);
    div  = (sel == 0) ? 1 : (sel == 1) ? 16 : 256;
    lo   = w ? int'(load) : int'(load & 32'hFFFF);
    ctrl = 32'h80 | ((mode == 1) ? 32'h40 : 0) | (ie ? 32'h20 : 0)
         | (32'(sel) << 2) | (w ? 32'h2 : 0) | ((mode == 2) ? 32'h1 : 0);
    wr(base + 8'h08, 32'h0);
    wr(base + 8'h0C, 32'hA5);
    wr(base + 8'h00, load);
    wr(base + 8'h08, ctrl);
    cyc_en = last_wr;
    for (int k = 0; k <= lo + 2; k++) begin
      while (cyc - cyc_en < k * div + div / 2) @(negedge clk);
      rd(base + 8'h04, v);
      n = (s_cyc - cyc_en) / div;
      rq = (tag != "") ? tag : (n <= lo) ? "R2" : (mode == 0) ? "R3" : (mode == 1) ? "R4" : "R5";
      check(rq, $sformatf("t%0d sel%0d mode%0d w%0d tick%0d value", tm, sel, mode, w, n),
            v, mdl_val(load, longint'(n), mode, w));
      rd(base + 8'h10, v);
      exp_ris = ((s_cyc - cyc_en) / div) >= lo;
      check("R6", $sformatf("t%0d sel%0d mode%0d RIS", tm, sel, mode), v, {31'b0, exp_ris});
      rd(base + 8'h14, v);
      exp_ris = ((s_cyc - cyc_en) / div) >= lo;
      check("R7", "MIS", v, {31'b0, exp_ris & ie});
      check("R7", "tmr_irq_o", {30'b0, s_irq}, {30'b0, exp_ris & ie} << tm);
      check("R7", "irq_any_o", {31'b0, s_any}, {31'b0, exp_ris & ie});
    end
    wr(base + 8'h08, 32'h0);
    wr(base + 8'h0C, 32'h0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(150000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int t = 0; t < 2; t++) begin
      rd(8'(t * 32 + 8'h10), v); check("R1", "RIS after reset", v, 32'h0);
      rd(8'(t * 32 + 8'h14), v); check("R1", "MIS after reset", v, 32'h0);
      rd(8'(t * 32 + 8'h04), v); check("R1", "VALUE after reset", v, 32'hFFFF_FFFF);
      rd(8'(t * 32 + 8'h08), v); check("R1", "CONTROL after reset", v, 32'h20);
      rd(8'(t * 32 + 8'h00), v); check("R1", "LOAD after reset", v, 32'h0);
    end
    check("R1", "irq after reset", {29'b0, s_any, s_irq}, 32'h0);

    // R11 unmapped and readback format
    rd(8'h1C, v); check("R11", "offset 0x1C", v, 32'h0);
    rd(8'h3C, v); check("R11", "offset 0x3C", v, 32'h0);
    rd(8'h40, v); check("R11", "offset 0x40", v, 32'h0);
    rd(8'h84, v); check("R11", "offset 0x84", v, 32'h0);
    rd(8'h0C, v); check("R11", "INTCLR read", v, 32'h0);
    wr(8'h28, 32'hFFFF_FF7F); rd(8'h28, v); check("R11", "CONTROL readback", v, 32'h6F);
    wr(8'h28, 32'h0);

    // R2..R7 sweep over timers, dividers, modes, widths
    for (int tm = 0; tm < 2; tm++)
      for (int sel = 0; sel < 3; sel++)
        for (int mode = 0; mode < 3; mode++)
          for (int w = 0; w < 2; w++)
            run_cfg(tm, sel, mode, w[0], w[0] ^ tm[0], 32'(3 + sel + mode), "");
    run_cfg(1, 3, 1, 1'b1, 1'b1, 32'd2, "R2");

    // R9 16-bit mode keeps upper half
    run_cfg(0, 0, 0, 1'b0, 1'b1, 32'h0001_0003, "R9");
    run_cfg(1, 0, 1, 1'b0, 1'b1, 32'h0002_0004, "R9");

    // R10 clear on the expiring edge
    wr(8'h20, 32'd6);
    wr(8'h28, 32'hA2);
    cyc_en = last_wr;
    wr_at(8'h2C, 32'h0, cyc_en + 6);
    rd(8'h30, v); check("R10", "RIS after coincident clear", v, 32'h1);
    check("R10", "tmr_irq_o[1]", {31'b0, s_irq[1]}, 32'h1);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h30, v); check("R6", "RIS after later clear", v, 32'h0);
    wr(8'h28, 32'h0);

    // R8 background reload and immediate load
    wr(8'h00, 32'd3);
    wr(8'h08, 32'hC6);
    cyc_en = last_wr;
    wr(8'h18, 32'd7);
    rd(8'h04, v); check("R8", "VALUE after BGLOAD", v, 32'd3 - 32'((s_cyc - cyc_en) / 16));
    rd(8'h00, v); check("R8", "LOAD reads reload", v, 32'd7);
    rd(8'h18, v); check("R8", "BGLOAD reads reload", v, 32'd7);
    while (cyc - cyc_en < 72) @(negedge clk);
    rd(8'h04, v);
    n = (s_cyc - cyc_en) / 16;
    check("R8", "reload from BGLOAD", v, 32'd7 - 32'(n - 4));
    do @(negedge clk); while ((cyc - cyc_en) % 16 != 2);
    wr_now(8'h00, 32'd9);
    rd(8'h04, v); check("R8", "LOAD sets count now", v, 32'd9);
    wr(8'h08, 32'h0);

    // R5 one-shot restart by LOAD while enabled
    wr(8'h20, 32'd3);
    wr(8'h28, 32'h83);
    repeat (10) @(negedge clk);
    rd(8'h24, v); check("R5", "one-shot held at zero", v, 32'h0);
    wr(8'h20, 32'd4);
    rd(8'h24, v); check("R5", "one-shot restart", v, 32'd4 - 32'(s_cyc - last_wr));
    repeat (10) @(negedge clk);
    rd(8'h24, v); check("R5", "one-shot stops again", v, 32'h0);
    wr(8'h28, 32'h0);

    summary();
    $finish;
  end

endmodule